// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Interrupt Routing

This block receives 8-bit asynchronous serial characters on a single input line. It uses a clock-enable that pulses at sixteen times the bit rate. When the line falls, the receiver waits half a bit time and samples the line again to confirm the start bit. It then samples each data bit, LSB first, in the middle of its bit period. An optional parity bit and one stop bit follow. When the stop bit has been sampled, the character goes into a receive buffer, and the block raises one or two single-cycle pulses: a receive-complete pulse and an error pulse.

A frame that carries a parity, framing or overrun error is still written into the buffer. The error pulse fires for every errored frame. A routing bit decides whether such a frame also raises the receive-complete pulse. The three error flags are sticky: they accumulate until the host pulses the buffer read strobe. Clearing the enable in the middle of a frame abandons the frame. The buffer, the flags and both pulses are then left untouched.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0, all three error flags are 0, and neither pulse is asserted.
- R2: A falling edge on `rxd` starts a half-bit wait of 8 `sample_en` ticks. If the line is still low at that sample, a start bit is accepted. If it is high, the receiver returns to idle, and a low glitch shorter than half a bit produces no frame.
- R3: After an accepted start bit, the receiver samples 8 data bits, LSB first, one every 16 ticks. It then samples the parity bit (when enabled) and one stop bit. The character appears on `rx_data` once the stop bit has been sampled.
- R4: `par_mode` encodes 00 = no parity bit in the frame, 01 = even, 10 = odd, 11 = parity bit must be 0. A received parity bit that breaks the selected rule sets `err_parity`.
- R5: A stop bit sampled low sets `err_frame`.
- R6: The data of a frame with any error is still written to `rx_data`.
- R7: A frame without error always raises `done_irq`. A frame with an error raises `done_irq` only when `err_route` is 0.
- R8: Every frame with a parity, framing or overrun error raises `err_irq`, whatever the value of `err_route`.
- R9: A frame that completes while the previous character has not been read sets `err_overrun`.
- R10: The error flags stay set until `rd_strobe` is pulsed. A read clears all three flags and marks the buffer as read.
- R11: While `rx_en` is 0, the line is ignored. Clearing `rx_en` during a frame aborts it: `rx_data` and the flags keep their values, and neither pulse fires.
- R12: `done_irq` and `err_irq` are each one clock cycle wide for each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sampling tick at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| err_route | input | 1 | 1: an errored frame does not raise done_irq |
| par_mode | input | 2 | Parity rule: 00 none, 01 even, 10 odd, 11 zero |
| rxd | input | 1 | Serial data line, idle high |
| rd_strobe | input | 1 | Buffer read strobe; clears the error flags |
| rx_data | output | 8 | Receive buffer |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| done_irq | output | 1 | Receive-complete pulse |
| err_irq | output | 1 | Receive-error pulse |

## Verification
A wrong bit counter or sample point shows up on the next frame: the buffer holds a shifted or misaligned character, and a mis-timed stop sample raises a framing error. A wrong idle/abort state shows up as a pulse that should not appear after a glitch, a disabled frame or an aborted frame. These cases are checked about two bit times after the line goes quiet. Faults in the buffer-status bookkeeping show up as a missing overrun flag, or as flags that do not clear or do not stick. They are visible on the frame that follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    // xr is the xor of all data bits, pbit the received parity bit
    function automatic logic parity_bad(par_mode_e mode, logic xr, logic pbit);
        logic bad;
        case (mode)
            PAR_EVEN: bad = xr ^ pbit;
            PAR_ODD:  bad = ~(xr ^ pbit);
            PAR_ZERO: bad = pbit;
            default:  bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // line idles high, so reset to 1 to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  par_mode_e         par_mode,
    input  logic              line,
    output logic              fr_valid,
    output logic [DATA_W-1:0] fr_data,
    output logic              fr_perr,
    output logic              fr_ferr
);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              prev;
        logic              perr;
        logic              vld;
        logic [DATA_W-1:0] odata;
        logic              operr;
        logic              oferr;
    } fr_state_t;

    fr_state_t s_d, s_q;
    logic      bit_end;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        bit_end = (s_q.cnt == BIT_LAST);

        if (tick) s_d.prev = line;

        if (!enable) begin
            s_d.st  = RX_IDLE;
            s_d.cnt = '0;
        end else if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (s_q.prev && !line) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == HALF_LAST) begin
                        s_d.cnt = '0;
                        if (!line) begin
                            s_d.st   = RX_DATA;
                            s_d.idx  = '0;
                            s_d.perr = 1'b0;
                        end else begin
                            s_d.st = RX_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        s_d.cnt = '0;
                        s_d.sh  = {line, s_q.sh[DATA_W-1:1]};
                        if (s_q.idx == IDX_LAST) begin
                            s_d.st = (par_mode == PAR_NONE) ? RX_STOP : RX_PAR;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (bit_end) begin
                        s_d.cnt  = '0;
                        s_d.perr = parity_bad(par_mode, ^s_q.sh, line);
                        s_d.st   = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        s_d.cnt   = '0;
                        s_d.st    = RX_IDLE;
                        s_d.vld   = 1'b1;
                        s_d.odata = s_q.sh;
                        s_d.operr = s_q.perr;
                        s_d.oferr = ~line;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= RX_IDLE;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fr_valid = s_q.vld;
    assign fr_data  = s_q.odata;
    assign fr_perr  = s_q.operr;
    assign fr_ferr  = s_q.oferr;
endmodule

// File: rtl/uart_rx_result.sv
module uart_rx_result #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_valid,
    input  logic [DATA_W-1:0] fr_data,
    input  logic              fr_perr,
    input  logic              fr_ferr,
    input  logic              rd_strobe,
    input  logic              err_route,
    output logic [DATA_W-1:0] buf_data,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_oerr,
    output logic              done_pulse,
    output logic              err_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              pe;
        logic              fe;
        logic              oe;
        logic              done;
        logic              err;
    } res_state_t;

    res_state_t r_d, r_q;
    logic       ovr;
    logic       any_err;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        ovr      = r_q.full & ~rd_strobe;
        any_err  = fr_perr | fr_ferr | ovr;

        if (rd_strobe) begin
            r_d.full = 1'b0;
            r_d.pe   = 1'b0;
            r_d.fe   = 1'b0;
            r_d.oe   = 1'b0;
        end

        if (fr_valid) begin
            r_d.data = fr_data;
            r_d.full = 1'b1;
            r_d.pe   = r_d.pe | fr_perr;
            r_d.fe   = r_d.fe | fr_ferr;
            r_d.oe   = r_d.oe | ovr;
            r_d.err  = any_err;
            r_d.done = ~any_err | ~err_route;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign buf_data   = r_q.data;
    assign st_perr    = r_q.pe;
    assign st_ferr    = r_q.fe;
    assign st_oerr    = r_q.oe;
    assign done_pulse = r_q.done;
    assign err_pulse  = r_q.err;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OSR         = 16,
    parameter int unsigned CNT_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_en,
    input  logic              err_route,
    input  logic [1:0]        par_mode,
    input  logic              rxd,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              done_irq,
    output logic              err_irq
);
    logic              line_s;
    logic              fr_valid;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    uart_rx_framer #(.DATA_W(DATA_W), .OSR(OSR), .CNT_W(CNT_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_en),
        .enable  (rx_en),
        .par_mode(par_mode_e'(par_mode)),
        .line    (line_s),
        .fr_valid(fr_valid),
        .fr_data (fr_data),
        .fr_perr (fr_perr),
        .fr_ferr (fr_ferr)
    );

    uart_rx_result #(.DATA_W(DATA_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .fr_valid  (fr_valid),
        .fr_data   (fr_data),
        .fr_perr   (fr_perr),
        .fr_ferr   (fr_ferr),
        .rd_strobe (rd_strobe),
        .err_route (err_route),
        .buf_data  (rx_data),
        .st_perr   (err_parity),
        .st_ferr   (err_frame),
        .st_oerr   (err_overrun),
        .done_pulse(done_irq),
        .err_pulse (err_irq)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              err_route,
    input logic              rd_strobe,
    input logic              fr_valid,
    input logic [DATA_W-1:0] fr_data,
    input logic [DATA_W-1:0] rx_data,
    input logic              err_parity,
    input logic              err_frame,
    input logic              err_overrun,
    input logic              done_irq,
    input logic              err_irq
);
    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R12
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    // R8
    err_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (err_parity || err_frame || err_overrun));

    // R7
    routed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && $past(err_route)) |-> !done_irq);

    // R6
    buffer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_valid |=> (rx_data == $past(fr_data)));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_parity || err_frame || err_overrun) && !rd_strobe) |=>
        ((err_parity || !$past(err_parity)) && (err_frame || !$past(err_frame)) &&
         (err_overrun || !$past(err_overrun))));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fr_valid) |=> (!err_parity && !err_frame && !err_overrun));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en)) |=> (!done_irq && !err_irq));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .err_route  (err_route),
    .rd_strobe  (rd_strobe),
    .fr_valid   (fr_valid),
    .fr_data    (fr_data),
    .rx_data    (rx_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .done_irq   (done_irq),
    .err_irq    (err_irq)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
    localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       err_route = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       err_parity, err_frame, err_overrun, done_irq, err_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_done   = 0;
    int n_err    = 0;

    // model state
    logic       m_full = 1'b0;
    logic       m_pe = 1'b0, m_fe = 1'b0, m_oe = 1'b0;
    logic [7:0] m_data = 8'h00;

    always #2.5 clk = ~clk;

    uart_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_en(rx_en),
        .err_route(err_route), .par_mode(par_mode), .rxd(rxd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .done_irq(done_irq), .err_irq(err_irq)
    );

    always @(negedge clk) begin
        if (done_irq) n_done++;
        if (err_irq)  n_err++;
    end

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            sample_en = (ph == 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic good_parity(input logic [1:0] mode, input logic [7:0] d);
        case (mode)
            2'b01:   return ^d;
            2'b10:   return ~(^d);
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic has_par,
                              input logic pbit, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (has_par) send_bit(pbit);
        send_bit(stop);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        m_full = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_oe = 1'b0;
    endtask

    task automatic check_state(input string req);
        check(rx_data == m_data, req, "rx_data", rx_data, m_data);
        check({err_parity, err_frame, err_overrun} == {m_pe, m_fe, m_oe}, req,
              "flags", {err_parity, err_frame, err_overrun}, {m_pe, m_fe, m_oe});
    endtask

    // sends one frame and checks buffer, flags and pulse counts against the model
    task automatic run_frame(input string req, input logic [7:0] d, input logic [1:0] mode,
                             input logic bad_par, input logic bad_stop, input logic route);
        int d0, e0;
        logic ov, er, pb;
        par_mode  = mode;
        err_route = route;
        pb = good_parity(mode, d) ^ bad_par;
        d0 = n_done; e0 = n_err;
        send_frame(d, mode != 2'b00, pb, ~bad_stop);
        ov = m_full;
        er = (bad_par && mode != 2'b00) | bad_stop | ov;
        m_data = d; m_full = 1'b1;
        m_pe |= bad_par && mode != 2'b00; m_fe |= bad_stop; m_oe |= ov;
        check_state(req);
        check(n_done - d0 == ((!er || !route) ? 1 : 0), req, "done_irq count",
              n_done - d0, (!er || !route) ? 1 : 0);
        check(n_err - e0 == (er ? 1 : 0), req, "err_irq count", n_err - e0, er ? 1 : 0);
    endtask

    initial begin
        int d0, e0;
        void'($urandom(32'h5eed_0417));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_data == 8'h00, "R1", "rx_data", rx_data, 0);
        check({err_parity, err_frame, err_overrun, done_irq, err_irq} == 5'b0, "R1", "flags/pulses",
              {err_parity, err_frame, err_overrun, done_irq, err_irq}, 0);

        // R11: disabled receiver ignores a whole frame
        d0 = n_done; e0 = n_err;
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        check(n_done == d0 && n_err == e0, "R11", "pulses while disabled", n_done - d0 + n_err - e0, 0);
        check(rx_data == 8'h00, "R11", "rx_data while disabled", rx_data, 0);

        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        // R3 clean frame, LSB first, no parity
        run_frame("R3", 8'hA5, 2'b00, 1'b0, 1'b0, 1'b0);
        do_read();
        run_frame("R3", 8'h01, 2'b00, 1'b0, 1'b0, 1'b1);
        do_read();
        // R10 read clears
        check_state("R10");

        // R2: short glitch, no frame
        d0 = n_done; e0 = n_err;
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * BIT_CLK) @(negedge clk);
        check(n_done == d0 && n_err == e0, "R2", "glitch pulses", n_done - d0 + n_err - e0, 0);
        run_frame("R2", 8'h80, 2'b00, 1'b0, 1'b0, 1'b0);
        do_read();

        // R4 parity modes, each good and bad
        run_frame("R4", 8'h07, 2'b01, 1'b0, 1'b0, 1'b0); do_read();
        run_frame("R4", 8'h07, 2'b01, 1'b1, 1'b0, 1'b0); do_read();
        run_frame("R4", 8'h0F, 2'b10, 1'b0, 1'b0, 1'b0); do_read();
        run_frame("R4", 8'h0F, 2'b10, 1'b1, 1'b0, 1'b1); do_read();
        run_frame("R4", 8'hFF, 2'b11, 1'b1, 1'b0, 1'b0); do_read();
        // R5 / R6 framing error with data stored, routed
        run_frame("R5", 8'h5A, 2'b00, 1'b0, 1'b1, 1'b1);
        // R10 flags stay until read
        repeat (3 * BIT_CLK) @(negedge clk);
        check_state("R10");
        do_read();
        // R9 overrun, then R7 with routing off
        run_frame("R9", 8'h11, 2'b00, 1'b0, 1'b0, 1'b0);
        run_frame("R9", 8'h22, 2'b00, 1'b0, 1'b0, 1'b1);
        run_frame("R7", 8'h33, 2'b01, 1'b0, 1'b0, 1'b0);
        do_read();

        // R11: abort mid frame
        run_frame("R11", 8'hC3, 2'b00, 1'b0, 1'b0, 1'b0);
        d0 = n_done; e0 = n_err;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        rx_en = 1'b0;
        rxd = 1'b1;
        repeat (10 * BIT_CLK) @(negedge clk);
        rx_en = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        check(n_done == d0 && n_err == e0, "R11", "abort pulses", n_done - d0 + n_err - e0, 0);
        check_state("R11");
        do_read();

        // R6/R7/R8 random mix
        for (int k = 0; k < 24; k++) begin
            logic [7:0] rd;
            logic [1:0] rm;
            rd = 8'($urandom);
            rm = 2'($urandom);
            run_frame("R8", rd, rm, 1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 1'($urandom));
            if ($urandom % 4 != 0) do_read();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule